// File: doc/BRIEF.md
# MDIO Management Slave

This block is the device-side end of a two-wire serial management bus: a clock driven by the station manager (`mdc`) and one bidirectional data line, here split into a sampled input and a drive/enable pair for the pad. The block samples the data line on every rising clock edge. It waits for a run of ones as the preamble, then decodes the start pattern, the opcode, the device address, the register address, the turnaround and 16 data bits. Write frames update a small register file. Read frames are answered by driving the line during the second turnaround bit and the data phase.

The device address comes from five strap pins. They are captured during reset into the low bits of a read-only strap register and are not sampled again. A control register drives the isolate level that fences off the data path. Management access is independent of that level, so a host can always clear isolate over the bus. Writes addressed to device 0 reach every device on the bus. Reads addressed to device 0 get no answer.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While `rst_n` is low at a rising `mdc` edge, `ctrl_q` becomes 0x0000, `isolate` becomes 0 and `mdio_oe` becomes 0.
- R2: `strap_q` holds `strap_pins` zero-extended to 16 bits, captured at rising edges during reset. It does not change after reset, whether the pins change or a frame writes to register address 0x10.
- R3: A frame is decoded only if at least 32 consecutive ones precede its start bits. With 31 ones, or with a start pattern other than 0 then 1, the frame is ignored and the decoder goes back to hunting for a preamble.
- R4: A frame laid out as start 01, opcode 01 (write), 5-bit device address MSB first, 5-bit register address MSB first, two turnaround bits and 16 data bits MSB first writes the data into register address 0x00 (`ctrl_q`) when the device address equals the strapped address. The new value is visible after the edge that samples the last data bit.
- R5: A write frame with device address 0 is accepted the same way as a write to the strapped address.
- R6: A read frame (opcode 10) to the strapped address leaves `mdio_oe` low during the first turnaround bit and drives 0 during the second. It then drives the 16 register bits MSB first, one bit per `mdc` period, and releases the line at the end of the last data bit.
- R7: A read to device address 0, and any frame to an address that is neither the strapped address nor 0, never raises `mdio_oe` and leaves `ctrl_q` unchanged.
- R8: `isolate` equals bit 10 of the register at address 0x00. Writing 1 there asserts it, and writing 0 releases it.
- R9: While `isolate` is high, reads and writes complete exactly as they do when it is low.
- R10: A write to a register address other than 0x00 or 0x10 changes nothing. A read of such an address is answered with 0x0000.
- R11: Frames with opcode 00 or 11 change no register and never raise `mdio_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; strap pins are captured while low |
| strap_pins | input | 5 | Device address strap inputs |
| mdio_i | input | 1 | Sampled level of the management data line |
| mdio_o | output | 1 | Level driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line during read turnaround and data |
| isolate | output | 1 | Data path isolate level (control register bit 10) |
| ctrl_q | output | 16 | Current control register value (address 0x00) |
| strap_q | output | 16 | Strap register value (address 0x10) |

## Verification
Two functions can fall on the same edge: the write commit at the last data bit that sets or clears the isolate bit, and the management decoding that has to keep working under that level. The bench sets isolate with one write frame. It then writes and reads the control register back while isolate stays high, with a read following directly after the write that changed the level. It clears isolate with a further frame. Each step is judged from the `isolate` and `ctrl_q` outputs and from the bit-by-bit read response on the line, including the turnaround drive and the release of the line after the last data bit.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the management slave: frame decoder states
// and opcode codes. Assumes a two-bit opcode field.
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,   // counting preamble ones
        ST_START,  // first start bit (0) seen, expecting 1
        ST_OP,     // shifting opcode
        ST_PHY,    // shifting device address
        ST_REG,    // shifting register address
        ST_TA,     // turnaround bits
        ST_DATA    // data bits
    } rx_state_e;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

endpackage

// File: rtl/mdio_frame_rx.sv
`timescale 1ns/1ps
// Frame decoder: hunts for a preamble of PRE_LEN ones, checks the start
// pattern, collects opcode and both addresses, and flags the turnaround
// edge of a read to this device and the last data edge of an accepted write.
// Assumes mdio_i is stable around the rising edge of mdc.
module mdio_frame_rx #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              rd_start,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data
);
    import mdio_mgmt_pkg::*;

    localparam int PRE_CW = $clog2(PRE_LEN + 1);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [PRE_CW-1:0] PRE_FULL  = PRE_CW'(PRE_LEN);
    localparam logic [CNT_W-1:0]  LAST_OP   = CNT_W'(1);
    localparam logic [CNT_W-1:0]  LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0]  LAST_DATA = CNT_W'(DATA_W - 1);

    rx_state_e         state;
    logic [PRE_CW-1:0] pre_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        op_sh;
    logic [ADDR_W-1:0] phy_sh;
    logic [ADDR_W-1:0] reg_sh;
    logic [DATA_W-2:0] data_sh;
    logic              wr_hit;
    logic              rd_hit;

    // Address and opcode qualification for the frame being received.
    always_comb begin
        wr_hit = (op_sh == OPC_WRITE) && ((phy_sh == own_addr) || (phy_sh == '0));
        rd_hit = (op_sh == OPC_READ) && (phy_sh == own_addr) && (phy_sh != '0);
    end

    assign rd_start  = (state == ST_TA) && (bit_cnt == '0) && rd_hit;
    assign wr_strobe = (state == ST_DATA) && (bit_cnt == LAST_DATA) && wr_hit;
    assign wr_data   = {data_sh, mdio_i};
    assign reg_addr  = reg_sh;

    // Frame state machine, one step per sampled bit.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            pre_cnt <= '0;
            bit_cnt <= '0;
            op_sh   <= '0;
            phy_sh  <= '0;
            reg_sh  <= '0;
            data_sh <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (mdio_i) begin
                        if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
                    end else begin
                        if (pre_cnt == PRE_FULL) state <= ST_START;
                        pre_cnt <= '0;
                    end
                end
                ST_START: begin
                    bit_cnt <= '0;
                    state   <= mdio_i ? ST_OP : ST_HUNT;
                end
                ST_OP: begin
                    op_sh <= {op_sh[0], mdio_i};
                    if (bit_cnt == LAST_OP) begin
                        bit_cnt <= '0;
                        state   <= ST_PHY;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_PHY: begin
                    phy_sh <= {phy_sh[ADDR_W-2:0], mdio_i};
                    if (bit_cnt == LAST_ADDR) begin
                        bit_cnt <= '0;
                        state   <= ST_REG;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_REG: begin
                    reg_sh <= {reg_sh[ADDR_W-2:0], mdio_i};
                    if (bit_cnt == LAST_ADDR) begin
                        bit_cnt <= '0;
                        state   <= ST_TA;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TA: begin
                    if (bit_cnt == LAST_OP) begin
                        bit_cnt <= '0;
                        state   <= ST_DATA;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    data_sh <= {data_sh[DATA_W-3:0], mdio_i};
                    if (bit_cnt == LAST_DATA) begin
                        bit_cnt <= '0;
                        pre_cnt <= '0;
                        state   <= ST_HUNT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
// Register file: a writable control register and a read-only strap
// register loaded from the strap pins while reset is held. Other
// addresses ignore writes and read as zero. Assumes DATA_W > ADDR_W.
module mdio_regfile #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = '0,
    parameter logic [ADDR_W-1:0] STRAP_ADDR = ADDR_W'(16),
    parameter logic [DATA_W-1:0] CTRL_RESET = '0
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_pins,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] strap_q
);

    // Control register: reset value, then updated by accepted writes.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_strobe && (reg_addr == CTRL_ADDR)) begin
            ctrl_q <= wr_data;
        end
    end

    // Strap register: follows the pins only while reset is held.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            strap_q <= DATA_W'(strap_pins);
        end
    end

    // Read multiplexer for the addressed register.
    always_comb begin
        if (reg_addr == CTRL_ADDR) begin
            rd_data = ctrl_q;
        end else if (reg_addr == STRAP_ADDR) begin
            rd_data = strap_q;
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/mdio_tx_shift.sv
`timescale 1ns/1ps
// Read response driver: on load it enables the line and drives 0 for the
// second turnaround bit, then shifts the register value out MSB first
// and releases the line one period after the last bit.
module mdio_tx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int REM_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg;
    logic [REM_W-1:0]  remain;

    // Turnaround drive, data shifting and release.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            shreg   <= '0;
            remain  <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (load) begin
            shreg   <= load_data;
            remain  <= REM_W'(DATA_W);
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b1;
        end else if (remain != '0) begin
            mdio_o  <= shreg[DATA_W-1];
            shreg   <= {shreg[DATA_W-2:0], 1'b0};
            remain  <= remain - 1'b1;
        end else begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
// Top of the management slave. The device address is the strap register
// low field; isolate is one bit of the control register. Everything is
// clocked by mdc, and the pad combines mdio_o/mdio_oe into the line.
module mdio_mgmt_slave #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32,
    parameter int ISO_BIT = 10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = '0,
    parameter logic [ADDR_W-1:0] STRAP_ADDR = ADDR_W'(16),
    parameter logic [DATA_W-1:0] CTRL_RESET = '0
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_pins,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              isolate,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] strap_q
);

    logic              rd_start;
    logic              wr_strobe;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    mdio_frame_rx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PRE_LEN(PRE_LEN)
    ) u_rx (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_i   (mdio_i),
        .own_addr (strap_q[ADDR_W-1:0]),
        .rd_start (rd_start),
        .wr_strobe(wr_strobe),
        .reg_addr (reg_addr),
        .wr_data  (wr_data)
    );

    mdio_regfile #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STRAP_ADDR(STRAP_ADDR),
        .CTRL_RESET(CTRL_RESET)
    ) u_regs (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .strap_pins(strap_pins),
        .wr_strobe (wr_strobe),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ctrl_q    (ctrl_q),
        .strap_q   (strap_q)
    );

    mdio_tx_shift #(
        .DATA_W(DATA_W)
    ) u_tx (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .load     (rd_start),
        .load_data(rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign isolate = ctrl_q[ISO_BIT];

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
`timescale 1ns/1ps
// Property checker for the management slave, bound into the top module.
// Measures the length of each read drive window with its own counter.
module mdio_mgmt_slave_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input logic              mdc,
    input logic              rst_n,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              rd_start,
    input logic              wr_strobe,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] strap_q
);
    logic [7:0] oe_run;

    // Counts consecutive edges with the line driven.
    always_ff @(posedge mdc) begin
        if (!rst_n)       oe_run <= '0;
        else if (mdio_oe) oe_run <= oe_run + 1'b1;
        else              oe_run <= '0;
    end

    assert_strap_frozen_R2: assert property (@(posedge mdc) disable iff (!rst_n)
        rst_n |=> $stable(strap_q));

    assert_ctrl_needs_write_R4: assert property (@(posedge mdc) disable iff (!rst_n)
        !wr_strobe |=> $stable(ctrl_q));

    assert_ta_low_R6: assert property (@(posedge mdc) disable iff (!rst_n)
        rd_start |=> (mdio_oe && !mdio_o));

    assert_drive_window_R6: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> (oe_run == 8'(DATA_W + 1)));

    assert_drive_origin_R7: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(rd_start));

    assert_no_zero_read_R7: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (strap_q[ADDR_W-1:0] != '0));

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_start (rd_start),
    .wr_strobe(wr_strobe),
    .ctrl_q   (ctrl_q),
    .strap_q  (strap_q)
);

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_pins = 5'h0C;
    logic        m_oe = 1'b1;
    logic        m_val = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic        isolate;
    logic [15:0] ctrl_q;
    logic [15:0] strap_q;
    logic        bus;
    logic        oe_seen;
    logic        done = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] exp_ctrl = 16'h0000;

    // Line model: slave drive wins, else master, else pull-up.
    assign bus = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);

    mdio_mgmt_slave uut (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .strap_pins(strap_pins),
        .mdio_i    (bus),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .isolate   (isolate),
        .ctrl_q    (ctrl_q),
        .strap_q   (strap_q)
    );

    always #10 mdc = ~mdc;

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge mdc);
        if (mdio_oe) oe_seen = 1'b1;
        m_oe  = 1'b1;
        m_val = b;
    endtask

    task automatic put_field(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
    endtask

    // Full frame from the master; a leading 0 clears any earlier run of ones.
    task automatic send_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                              input logic [4:0] phy, input logic [4:0] ra,
                              input logic [15:0] data);
        oe_seen = 1'b0;
        put_bit(1'b0);
        for (int i = 0; i < pre; i++) put_bit(1'b1);
        put_field(16'(st), 2);
        put_field(16'(op), 2);
        put_field(16'(phy), 5);
        put_field(16'(ra), 5);
        put_field(16'h0002, 2);
        put_field(data, 16);
        put_bit(1'b1);
    endtask

    // Read frame; checks turnaround, data bits, release and presence of drive.
    task automatic do_read(input string tag, input logic [4:0] phy, input logic [4:0] ra,
                           input logic expect_resp, input logic [15:0] exp);
        logic [15:0] got;
        logic        ta1_oe, ta2_low, all_oe, end_oe;
        oe_seen = 1'b0;
        put_bit(1'b0);
        for (int i = 0; i < 32; i++) put_bit(1'b1);
        put_field(16'h0001, 2);
        put_field(16'h0002, 2);
        put_field(16'(phy), 5);
        put_field(16'(ra), 5);
        @(negedge mdc);
        m_oe = 1'b0;
        ta1_oe = mdio_oe;
        @(negedge mdc);
        ta2_low = mdio_oe && !mdio_o;
        if (mdio_oe) oe_seen = 1'b1;
        all_oe = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge mdc);
            got[i] = bus;
            all_oe = all_oe & mdio_oe;
            if (mdio_oe) oe_seen = 1'b1;
        end
        @(negedge mdc);
        end_oe = mdio_oe;
        m_oe = 1'b1;
        m_val = 1'b1;
        if (expect_resp) begin
            check(tag, "turnaround 1 released", 16'(ta1_oe), 16'h0);
            check(tag, "turnaround 2 driven low", 16'(ta2_low), 16'h1);
            check(tag, "drive held over data", 16'(all_oe), 16'h1);
            check(tag, "read data", got, exp);
            check(tag, "released after data", 16'(end_oe), 16'h0);
        end else begin
            check(tag, "no drive on ignored read", 16'(oe_seen), 16'h0);
        end
    endtask

    task automatic t_reset;
        check("R1", "ctrl after reset", ctrl_q, 16'h0000);
        check("R1", "isolate after reset", 16'(isolate), 16'h0);
        check("R1", "oe after reset", 16'(mdio_oe), 16'h0);
        check("R2", "strap captured", strap_q, 16'h000C);
    endtask

    task automatic t_write_read;
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h00, 16'h1234);
        exp_ctrl = 16'h1234;
        check("R4", "write to own address", ctrl_q, exp_ctrl);
        check("R4", "no drive during write", 16'(oe_seen), 16'h0);
        check("R8", "isolate low with bit10 clear", 16'(isolate), 16'h0);
        do_read("R6", 5'h0C, 5'h00, 1'b1, exp_ctrl);
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h00, 16'hA5C3);
        exp_ctrl = 16'hA5C3;
        do_read("R6", 5'h0C, 5'h00, 1'b1, exp_ctrl);
    endtask

    task automatic t_isolate;
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h00, 16'h0400);
        exp_ctrl = 16'h0400;
        check("R8", "isolate set by bit10", 16'(isolate), 16'h1);
        do_read("R9", 5'h0C, 5'h00, 1'b1, exp_ctrl);
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h00, 16'h8C01);
        exp_ctrl = 16'h8C01;
        check("R9", "write while isolated", ctrl_q, exp_ctrl);
        check("R9", "isolate kept", 16'(isolate), 16'h1);
        do_read("R9", 5'h0C, 5'h00, 1'b1, exp_ctrl);
        do_read("R9", 5'h0C, 5'h10, 1'b1, 16'h000C);
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h00, 16'h0000);
        exp_ctrl = 16'h0000;
        check("R8", "isolate cleared", 16'(isolate), 16'h0);
    endtask

    task automatic t_broadcast;
        send_frame(32, 2'b01, 2'b01, 5'h00, 5'h00, 16'h0055);
        exp_ctrl = 16'h0055;
        check("R5", "broadcast write", ctrl_q, exp_ctrl);
        do_read("R7", 5'h00, 5'h00, 1'b0, 16'h0000);
    endtask

    task automatic t_other_addr;
        send_frame(32, 2'b01, 2'b01, 5'h05, 5'h00, 16'hFFFF);
        check("R7", "foreign write ignored", ctrl_q, exp_ctrl);
        check("R7", "no drive on foreign write", 16'(oe_seen), 16'h0);
        do_read("R7", 5'h05, 5'h00, 1'b0, 16'h0000);
    endtask

    task automatic t_strap;
        strap_pins = 5'h03;
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h10, 16'hFFFF);
        check("R2", "strap not writable", strap_q, 16'h000C);
        check("R2", "strap not re-sampled", strap_q, 16'h000C);
        do_read("R2", 5'h0C, 5'h10, 1'b1, 16'h000C);
        send_frame(32, 2'b01, 2'b01, 5'h03, 5'h00, 16'h7E7E);
        check("R2", "new pin value not an address", ctrl_q, exp_ctrl);
    endtask

    task automatic t_preamble;
        send_frame(31, 2'b01, 2'b01, 5'h0C, 5'h00, 16'h1111);
        check("R3", "short preamble ignored", ctrl_q, exp_ctrl);
        send_frame(32, 2'b00, 2'b01, 5'h0C, 5'h00, 16'h2222);
        check("R3", "bad start ignored", ctrl_q, exp_ctrl);
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h00, 16'h3333);
        exp_ctrl = 16'h3333;
        check("R3", "decoder recovers", ctrl_q, exp_ctrl);
    endtask

    task automatic t_unimpl;
        send_frame(32, 2'b01, 2'b01, 5'h0C, 5'h05, 16'hBEEF);
        check("R10", "unimplemented write dropped", ctrl_q, exp_ctrl);
        do_read("R10", 5'h0C, 5'h05, 1'b1, 16'h0000);
    endtask

    task automatic t_opcode;
        send_frame(32, 2'b01, 2'b11, 5'h0C, 5'h00, 16'h7777);
        check("R11", "opcode 11 ignored", ctrl_q, exp_ctrl);
        check("R11", "no drive on opcode 11", 16'(oe_seen), 16'h0);
        send_frame(32, 2'b01, 2'b00, 5'h0C, 5'h00, 16'h7777);
        check("R11", "opcode 00 ignored", ctrl_q, exp_ctrl);
        check("R11", "no drive on opcode 00", 16'(oe_seen), 16'h0);
    endtask

    initial begin
        oe_seen = 1'b0;
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        t_reset();
        t_write_read();
        t_isolate();
        t_broadcast();
        t_other_addr();
        t_strap();
        t_preamble();
        t_unimpl();
        t_opcode();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule